// File: doc/BRIEF.md
# Serial Controller Command Register

This block is the write-only command byte of a serial communication controller. The CPU writes the byte on its own fast clock. The block holds the byte and carries a request across to the slower controller clock. There it splits the byte into one-clock command strobes: release receive space, reset the receiver, reset the sequence counters, start the timer, send a transparent frame, send an information frame, mark end of message, reset the transmitter, and repeat transmission.

A busy flag in the CPU domain stays high from the accepted write until the command has run and the acknowledge has come back. Software polls this flag before it writes again. A write that arrives while busy is set is dropped and raises a sticky lost-command flag.

A two-bit mode input sets what bit 5 means. In auto mode it sets a receiver-not-ready level. In the extended transparent modes it requests repeated transmission. A repeat level tracks cyclic transmission until a transmitter reset. With DMA operation enabled, a receive-message-end event closes a DMA permission gate, and only a receiver reset opens it again.

Top module: `sercmd_reg`

## Requirements
- R1: After reset, all strobes are 0, `busy`, `lost_cmd`, `rx_not_ready` and `repeat_on` are 0, and `dma_allow` is 1.
- R2: Command byte bits map to strobes as follows: bit 7 to `stb_rx_release`, bit 6 to `stb_rx_reset`, bit 4 to `stb_timer`, bit 3 to `stb_tx_transp`, bit 2 to `stb_tx_iframe`, bit 1 to `stb_msg_end`, and bit 0 to `stb_tx_reset`. Every strobe of one command rises in the same controller cycle and lasts exactly one cycle.
- R3: The strobes of a command appear on the third rising `ctl_clk` edge after the `cpu_clk` edge that accepts the write, which is never more than three controller edges.
- R4: `busy` is 1 from the `cpu_clk` cycle after an accepted write until after the strobes have appeared. It is still 1 in the controller cycle that shows the strobes, and it returns to 0 within 30 CPU cycles.
- R5: A write while `busy` is 1 is ignored: it produces no strobes and no level change, and it sets `lost_cmd`, which then stays 1 until reset.
- R6: In auto mode (`mode` = 2'b00), bit 6 also pulses `stb_seq_reset` together with `stb_rx_reset`. In other modes `stb_seq_reset` stays 0.
- R7: In auto mode, every command loads bit 5 into `rx_not_ready` (1 means not ready, 0 means ready). In other modes `rx_not_ready` keeps its value.
- R8: In the extended transparent modes (`mode` = 2'b10 or 2'b11), bit 5 pulses `stb_tx_repeat`. In modes 2'b00 and 2'b01 bit 5 never produces that strobe.
- R9: In a transparent mode, a command with bits 5, 3 and 1 all set sets `repeat_on`. Any command with bit 0 set clears it, and the clear wins when both apply.
- R10: With `dma_mode` = 1, a one-cycle `rx_msg_end` pulse drives `dma_allow` to 0 on the next controller edge. It stays 0 until a command with bit 6 executes. With `dma_mode` = 0, `rx_msg_end` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU bus clock |
| cpu_rst | input | 1 | Synchronous active-high reset, CPU domain |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 8 | Command byte |
| busy | output | 1 | Command in flight; software polls before writing |
| lost_cmd | output | 1 | Sticky: a write was dropped while busy |
| ctl_clk | input | 1 | Controller clock |
| ctl_rst | input | 1 | Synchronous active-high reset, controller domain |
| mode | input | 2 | 00 auto, 01 plain, 10/11 extended transparent |
| dma_mode | input | 1 | DMA operation enabled |
| rx_msg_end | input | 1 | Receive-message-end event pulse |
| stb_rx_release | output | 1 | Release receive FIFO space |
| stb_rx_reset | output | 1 | Clear receiver and receive FIFO |
| stb_seq_reset | output | 1 | Clear sequence number counters (auto mode) |
| stb_timer | output | 1 | Start timer |
| stb_tx_transp | output | 1 | Send transparent frame |
| stb_tx_iframe | output | 1 | Send information frame |
| stb_msg_end | output | 1 | Message end |
| stb_tx_reset | output | 1 | Reset transmitter |
| stb_tx_repeat | output | 1 | Transmission repeat request |
| rx_not_ready | output | 1 | Receiver status level for acknowledgements |
| repeat_on | output | 1 | Cyclic transmission active |
| dma_allow | output | 1 | DMA requests permitted |

## Verification
The bench sweeps all 256 command bytes under each of the four modes. For every command it checks the strobe pattern, the exact controller edge on which the strobes land, and the busy window. A design that decoded bit 5 without looking at the mode would pulse repeat or change the receiver status in the wrong mode. A design that lost a synchronizer stage or added one would show its strobes one edge early or late. A back-to-back write probes the drop path: a design that accepted it would show a second strobe or overwrite the held byte before execution. The repeat level is checked with set and clear in the same byte, and the DMA gate is checked in both DMA settings.

// File: rtl/sercmd_pkg.sv
`timescale 1ns/100ps
package sercmd_pkg;

    localparam int CMD_W = 8;

    typedef enum logic [1:0] {
        MODE_AUTO  = 2'b00,
        MODE_PLAIN = 2'b01,
        MODE_XT0   = 2'b10,
        MODE_XT1   = 2'b11
    } op_mode_e;

    // Field order follows bit 7 down to bit 0 of the command byte.
    typedef struct packed {
        logic rx_release;
        logic rx_reset;
        logic dual_b5;
        logic timer;
        logic tx_transp;
        logic tx_iframe;
        logic msg_end;
        logic tx_reset;
    } cmd_s;

    typedef struct packed {
        logic rx_release;
        logic rx_reset;
        logic seq_reset;
        logic timer;
        logic tx_transp;
        logic tx_iframe;
        logic msg_end;
        logic tx_reset;
        logic tx_repeat;
    } strobe_s;

    function automatic logic is_auto(op_mode_e m);
        return m == MODE_AUTO;
    endfunction

    function automatic logic is_transparent(op_mode_e m);
        return m == MODE_XT0 || m == MODE_XT1;
    endfunction

    function automatic logic wants_repeat(cmd_s c);
        return c.dual_b5 & c.tx_transp & c.msg_end;
    endfunction

    function automatic strobe_s decode_cmd(cmd_s c, op_mode_e m);
        strobe_s s;
        s.rx_release = c.rx_release;
        s.rx_reset   = c.rx_reset;
        s.seq_reset  = c.rx_reset & is_auto(m);
        s.timer      = c.timer;
        s.tx_transp  = c.tx_transp;
        s.tx_iframe  = c.tx_iframe;
        s.msg_end    = c.msg_end;
        s.tx_reset   = c.tx_reset;
        s.tx_repeat  = c.dual_b5 & is_transparent(m);
        return s;
    endfunction

endpackage

// File: rtl/sercmd_sync.sv
`timescale 1ns/100ps
module sercmd_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sercmd_cpu_port.sv
`timescale 1ns/100ps
module sercmd_cpu_port
    import sercmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_data,
    input  logic             ack_tgl,
    output logic [CMD_W-1:0] hold_q,
    output logic             req_tgl,
    output logic             busy,
    output logic             lost_cmd
);
    logic ack_s;
    logic accept;

    sercmd_sync #(.STAGES(SYNC_STAGES), .W(1)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_tgl),
        .q   (ack_s)
    );

    assign busy   = req_tgl ^ ack_s;
    assign accept = wr_en & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            req_tgl  <= 1'b0;
            lost_cmd <= 1'b0;
        end else begin
            if (accept) begin
                hold_q  <= wr_data;
                req_tgl <= ~req_tgl;
            end
            if (wr_en && busy) lost_cmd <= 1'b1;
        end
    end

    // R4: held byte stays fixed while the controller may still read it
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(hold_q));
    // R5: a write during busy raises the lost flag
    a_r5_drop_flags: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> lost_cmd);
    // R5: the lost flag is sticky
    a_r5_lost_sticky: assert property (@(posedge clk) disable iff (rst)
        lost_cmd |=> lost_cmd);
endmodule

// File: rtl/sercmd_exec.sv
`timescale 1ns/100ps
module sercmd_exec
    import sercmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CMD_W-1:0] hold_q,
    input  logic             req_tgl,
    input  logic [1:0]       mode,
    input  logic             dma_mode,
    input  logic             rx_msg_end,
    output logic             ack_tgl,
    output strobe_s          strb,
    output logic             rx_not_ready,
    output logic             repeat_on,
    output logic             dma_allow
);
    logic     req_s;
    logic     req_d;
    logic     fire;
    cmd_s     cmd;
    op_mode_e m;
    logic     dma_block;

    sercmd_sync #(.STAGES(SYNC_STAGES), .W(1)) u_req_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_tgl),
        .q   (req_s)
    );

    assign fire    = req_s ^ req_d;
    assign cmd     = cmd_s'(hold_q);
    assign m       = op_mode_e'(mode);
    assign ack_tgl = req_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_d        <= 1'b0;
            strb         <= '0;
            rx_not_ready <= 1'b0;
            repeat_on    <= 1'b0;
            dma_block    <= 1'b0;
        end else begin
            req_d <= req_s;
            strb  <= fire ? decode_cmd(cmd, m) : '0;
            if (fire && is_auto(m)) rx_not_ready <= cmd.dual_b5;
            if (fire) begin
                if (cmd.tx_reset)
                    repeat_on <= 1'b0;
                else if (is_transparent(m) && wants_repeat(cmd))
                    repeat_on <= 1'b1;
            end
            if (fire && cmd.rx_reset)        dma_block <= 1'b0;
            else if (dma_mode && rx_msg_end) dma_block <= 1'b1;
        end
    end

    assign dma_allow = ~dma_block;

    // R2: every strobe lasts one cycle
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (|strb) |=> !(|strb));
    // R6: sequence reset only with receiver reset in auto mode
    a_r6_seq_auto: assert property (@(posedge clk) disable iff (rst)
        strb.seq_reset |-> (strb.rx_reset && $past(mode) == MODE_AUTO));
    // R8: repeat strobe only in transparent modes
    a_r8_repeat_mode: assert property (@(posedge clk) disable iff (rst)
        strb.tx_repeat |-> $past(mode[1]));
    // R10: the DMA gate reopens only together with a receiver reset strobe
    a_r10_reopen: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_allow) |-> strb.rx_reset);
endmodule

// File: rtl/sercmd_reg.sv
`timescale 1ns/100ps
module sercmd_reg
    import sercmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       cpu_clk,
    input  logic       cpu_rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       busy,
    output logic       lost_cmd,
    input  logic       ctl_clk,
    input  logic       ctl_rst,
    input  logic [1:0] mode,
    input  logic       dma_mode,
    input  logic       rx_msg_end,
    output logic       stb_rx_release,
    output logic       stb_rx_reset,
    output logic       stb_seq_reset,
    output logic       stb_timer,
    output logic       stb_tx_transp,
    output logic       stb_tx_iframe,
    output logic       stb_msg_end,
    output logic       stb_tx_reset,
    output logic       stb_tx_repeat,
    output logic       rx_not_ready,
    output logic       repeat_on,
    output logic       dma_allow
);
    logic [CMD_W-1:0] hold_q;
    logic             req_tgl;
    logic             ack_tgl;
    strobe_s          strb;

    sercmd_cpu_port #(.SYNC_STAGES(SYNC_STAGES)) u_cpu (
        .clk      (cpu_clk),
        .rst      (cpu_rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ack_tgl  (ack_tgl),
        .hold_q   (hold_q),
        .req_tgl  (req_tgl),
        .busy     (busy),
        .lost_cmd (lost_cmd)
    );

    sercmd_exec #(.SYNC_STAGES(SYNC_STAGES)) u_exec (
        .clk          (ctl_clk),
        .rst          (ctl_rst),
        .hold_q       (hold_q),
        .req_tgl      (req_tgl),
        .mode         (mode),
        .dma_mode     (dma_mode),
        .rx_msg_end   (rx_msg_end),
        .ack_tgl      (ack_tgl),
        .strb         (strb),
        .rx_not_ready (rx_not_ready),
        .repeat_on    (repeat_on),
        .dma_allow    (dma_allow)
    );

    assign stb_rx_release = strb.rx_release;
    assign stb_rx_reset   = strb.rx_reset;
    assign stb_seq_reset  = strb.seq_reset;
    assign stb_timer      = strb.timer;
    assign stb_tx_transp  = strb.tx_transp;
    assign stb_tx_iframe  = strb.tx_iframe;
    assign stb_msg_end    = strb.msg_end;
    assign stb_tx_reset   = strb.tx_reset;
    assign stb_tx_repeat  = strb.tx_repeat;
endmodule

// File: tb/tb_sercmd_reg.sv
`timescale 1ns/100ps
module tb_sercmd_reg;
    logic cpu_clk = 1'b0, ctl_clk = 1'b0;
    logic cpu_rst = 1'b1, ctl_rst = 1'b1;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] mode = 2'b00;
    logic dma_mode = 1'b0, rx_msg_end = 1'b0;
    logic busy, lost_cmd;
    logic stb_rx_release, stb_rx_reset, stb_seq_reset, stb_timer, stb_tx_transp;
    logic stb_tx_iframe, stb_msg_end, stb_tx_reset, stb_tx_repeat;
    logic rx_not_ready, repeat_on, dma_allow;

    int errors = 0, checks = 0;
    logic exp_rnr = 0, exp_rep = 0, exp_lost = 0, exp_allow = 1;

    sercmd_reg dut (.*);

    always #4 cpu_clk = ~cpu_clk;          // 125 MHz
    initial begin #3; forever #10 ctl_clk = ~ctl_clk; end

    function automatic logic [8:0] got_strobes();
        return {stb_rx_release, stb_rx_reset, stb_seq_reset, stb_timer, stb_tx_transp,
                stb_tx_iframe, stb_msg_end, stb_tx_reset, stb_tx_repeat};
    endfunction

    function automatic logic [8:0] want_strobes(logic [7:0] v, logic [1:0] md);
        return {v[7], v[6], v[6] & (md == 2'b00), v[4], v[3], v[2], v[1], v[0], v[5] & md[1]};
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic observe(output int nz, output int first, output logic [8:0] val,
                           output logic busy_at);
        nz = 0; first = 0; val = '0; busy_at = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            @(posedge ctl_clk); #0.5;
            if (got_strobes() != 0) begin
                nz++;
                if (first == 0) begin first = k; val = got_strobes(); busy_at = busy; end
            end
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 30) begin @(negedge cpu_clk); n++; end
        check(!busy, "R4 busy clears", busy, 0);
    endtask

    task automatic finish_levels(input logic [7:0] v);
        if (mode == 2'b00) exp_rnr = v[5];
        if (v[0]) exp_rep = 1'b0;
        else if (mode[1] && v[5] && v[3] && v[1]) exp_rep = 1'b1;
        if (v[6]) exp_allow = 1'b1;
    endtask

    task automatic run_cmd(input logic [7:0] v);
        int nz, first; logic [8:0] val; logic b; logic [8:0] w;
        w = want_strobes(v, mode);
        @(negedge cpu_clk); wr_en = 1'b1; wr_data = v;
        @(posedge cpu_clk); #0.5; wr_en = 1'b0;
        check(busy, "R4 busy after write", busy, 1);
        observe(nz, first, val, b);
        finish_levels(v);
        if (w == 0) check(nz == 0, "R2 no strobes", nz, 0);
        else begin
            check(nz == 1 && val == w, "R2 strobe pattern", val, w);
            check(first == 3, "R3 latency", first, 3);
            check(b, "R4 busy during execute", b, 1);
        end
        wait_idle();
        check(rx_not_ready == exp_rnr, "R7 receiver status", rx_not_ready, exp_rnr);
        check(repeat_on == exp_rep, "R9 repeat level", repeat_on, exp_rep);
        check(lost_cmd == exp_lost, "R5 lost flag", lost_cmd, exp_lost);
        check(dma_allow == exp_allow, "R10 dma gate", dma_allow, exp_allow);
    endtask

    initial begin
        #150000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (6) @(posedge ctl_clk);
        @(negedge cpu_clk); cpu_rst = 1'b0;
        @(negedge ctl_clk); ctl_rst = 1'b0;
        repeat (3) @(negedge cpu_clk);
        // R1 reset state
        check(got_strobes() == 0, "R1 strobes idle", got_strobes(), 0);
        check(!busy && !lost_cmd, "R1 busy/lost", {busy, lost_cmd}, 0);
        check(!rx_not_ready && !repeat_on && dma_allow, "R1 levels",
              {rx_not_ready, repeat_on, dma_allow}, 3'b001);

        // R2 R3 R6 R7 R8 R9: every byte in every mode
        for (int md = 0; md < 4; md++) begin
            mode = md[1:0];
            for (int v = 0; v < 256; v++) run_cmd(v[7:0]);
        end

        // R9: set then clear-wins in transparent mode
        mode = 2'b10;
        run_cmd(8'h2A);
        check(repeat_on, "R9 repeat set", repeat_on, 1);
        run_cmd(8'h2B);
        check(!repeat_on, "R9 clear wins", repeat_on, 0);

        // R5: second write while busy is dropped
        begin
            int nz, first; logic [8:0] val; logic b;
            mode = 2'b00;
            @(negedge cpu_clk); wr_en = 1'b1; wr_data = 8'h80;
            @(negedge cpu_clk); wr_data = 8'h21;
            @(negedge cpu_clk); wr_en = 1'b0;
            check(lost_cmd, "R5 lost raised", lost_cmd, 1);
            observe(nz, first, val, b);
            check(nz == 1 && val == want_strobes(8'h80, 2'b00), "R5 dropped write",
                  val, want_strobes(8'h80, 2'b00));
            wait_idle();
            exp_lost = 1'b1;
            finish_levels(8'h80);
            check(rx_not_ready == 1'b0, "R5 no level change", rx_not_ready, 0);
            run_cmd(8'h00);
        end

        // R10: DMA gate
        dma_mode = 1'b0;
        @(negedge ctl_clk); rx_msg_end = 1'b1;
        @(negedge ctl_clk); rx_msg_end = 1'b0;
        check(dma_allow, "R10 ignored without dma", dma_allow, 1);
        dma_mode = 1'b1;
        @(negedge ctl_clk); rx_msg_end = 1'b1;
        @(negedge ctl_clk); rx_msg_end = 1'b0;
        check(!dma_allow, "R10 gate closes", dma_allow, 0);
        exp_allow = 1'b0;
        run_cmd(8'h10);
        run_cmd(8'h40);
        check(dma_allow, "R10 gate reopens", dma_allow, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule